// File: doc/BRIEF.md
# Minutes-Seconds-Hundredths Stopwatch Core

This block measures elapsed time with a resolution of one hundredth of a second and a range that stops just short of one hour. It keeps three counting stages: hundredths, seconds and minutes. Each stage holds its value as a pair of BCD digits, units and tens. A one-cycle 100 Hz tick input advances the hundredths stage while the run control is high. When a stage reaches its terminal value, it wraps to zero. In the same clock edge, it advances the stage above it.

The stages are chained through synchronous carry enables on a single clock. The storage is one modulo-100 counter and two modulo-60 counters. There is never a single counter of all elapsed ticks. When the whole display rolls from 59:59.99 to 00:00.00, a one-cycle wrap flag marks the event, and counting continues from zero.

The tick source and the display driver sit outside the block. The six digit values are exported unchanged. The tens limit of each stage is a parameter, so smaller configurations can be built for exhaustive checking.

Top module: `stopwatch_core`

## Requirements
- R1: While rst_n is low at a clock edge, all six digits become 0 and wrap becomes 0, whatever the values of run and tick.
- R2: A clock edge with run=1 and tick=1 advances the hundredths value by one. The value is hund_tens*10+hund_units, with units 0..9 and tens 0..9 by default. From 99 it returns to 00.
- R3: While run=0, tick pulses are ignored and all six digits hold their values.
- R4: The seconds value (sec_tens*10+sec_units) changes only on the edge where an accepted tick takes hundredths from 99 to 00. On that edge it advances by one, and from 59 it returns to 00.
- R5: The minutes value (min_tens*10+min_units) changes only on the edge where an accepted tick takes both hundredths and seconds to 00 together. On that edge it advances by one, and from 59 it returns to 00.
- R6: After an accepted tick at 59:59.99, all digits read 0 and wrap is 1 for exactly the following cycle. At every other time, wrap is 0.
- R7: Every units digit stays in 0..9. The tens digits stay in 0..9 for hundredths and in 0..5 for seconds and minutes.
- R8: While run=1 and tick=0, all digits hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | 1 = counting enabled, 0 = stopped |
| tick | input | 1 | One-cycle 100 Hz enable pulse |
| hund_units | output | 4 | Hundredths units digit (BCD) |
| hund_tens | output | 4 | Hundredths tens digit (BCD) |
| sec_units | output | 4 | Seconds units digit (BCD) |
| sec_tens | output | 4 | Seconds tens digit (BCD) |
| min_units | output | 4 | Minutes units digit (BCD) |
| min_tens | output | 4 | Minutes tens digit (BCD) |
| wrap | output | 1 | One-cycle pulse after a rollover from 59:59.99 |

## Verification
The assertions check these on every cycle:
- digit ranges;
- holding while stopped or without a tick;
- the one-step advance of each stage;
- the rule that seconds and minutes move only on the edge where the stages below them roll over;
- the wrap pulse together with the all-zero state.

Only the bench's scenarios show the following:
- the reset-to-zero behaviour;
- agreement with an arithmetic model of the elapsed time across long, irregular tick and run patterns;
- a complete rollover with continued counting after it.

The full rollover is reached in a reduced configuration whose stage limits are small.

// File: rtl/stopwatch_pkg.sv
// Package: shared types and constants for the stopwatch core.
// Assumes BCD digits are four bits wide and units always run 0..9.
package stopwatch_pkg;
    typedef logic [3:0] bcd_t;

    localparam int unsigned NUM_STAGES = 3;
    localparam int unsigned UNITS_LAST = 9;

    typedef enum int unsigned {
        STG_HUND = 0,
        STG_SEC  = 1,
        STG_MIN  = 2
    } stage_e;
endpackage

// File: rtl/bcd_digit.sv
// Module: one BCD digit that counts 0..LAST and returns to 0 when stepped at LAST.
// Assumes step is a synchronous enable; reset is synchronous and active low.
module bcd_digit
    import stopwatch_pkg::*;
#(
    parameter int unsigned LAST = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output bcd_t value,
    output logic at_last
);
    localparam bcd_t LAST_CODE = bcd_t'(LAST);

    bcd_t value_q;

    // Flag the terminal value so the owner can build a carry.
    assign at_last = (value_q == LAST_CODE);
    assign value   = value_q;

    // Advance or wrap the digit on an enabled edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_q <= '0;
        end else if (step) begin
            value_q <= at_last ? '0 : value_q + bcd_t'(1);
        end
    end
endmodule

// File: rtl/bcd_stage.sv
// Module: two-digit BCD stage (units then tens) with a same-cycle carry out.
// Assumes the enable comes from the stage below or the tick; carry_out is combinational.
module bcd_stage
    import stopwatch_pkg::*;
#(
    parameter int unsigned TENS_LAST = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output bcd_t units,
    output bcd_t tens,
    output logic carry_out
);
    logic units_last;
    logic tens_last;
    logic tens_step;

    // The tens digit moves only when the units digit wraps.
    assign tens_step = enable && units_last;
    // The stage wraps when both digits sit at their terminal values.
    assign carry_out = tens_step && tens_last;

    bcd_digit #(.LAST(UNITS_LAST)) u_units (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (enable),
        .value   (units),
        .at_last (units_last)
    );

    bcd_digit #(.LAST(TENS_LAST)) u_tens (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (tens_step),
        .value   (tens),
        .at_last (tens_last)
    );
endmodule

// File: rtl/stopwatch_core.sv
// Module: hundredths/seconds/minutes stopwatch built from chained BCD stages.
// Assumes tick is a one-cycle pulse at 100 Hz, synchronous to clk; carries are
// enables on the same clock, so a ripple through all stages lands on one edge.
module stopwatch_core
    import stopwatch_pkg::*;
#(
    parameter int unsigned HUND_TENS_MAX = 9,
    parameter int unsigned SEC_TENS_MAX  = 5,
    parameter int unsigned MIN_TENS_MAX  = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic [3:0] hund_units,
    output logic [3:0] hund_tens,
    output logic [3:0] sec_units,
    output logic [3:0] sec_tens,
    output logic [3:0] min_units,
    output logic [3:0] min_tens,
    output logic wrap
);
    // Select the tens limit for each stage index.
    function automatic int unsigned tens_cap(input int unsigned idx);
        case (idx)
            STG_HUND: return HUND_TENS_MAX;
            STG_SEC:  return SEC_TENS_MAX;
            default:  return MIN_TENS_MAX;
        endcase
    endfunction

    logic stage_en [NUM_STAGES+1];
    bcd_t st_units [NUM_STAGES];
    bcd_t st_tens  [NUM_STAGES];
    logic wrap_q;

    // An accepted tick drives the lowest stage.
    assign stage_en[0] = run && tick;

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
        bcd_stage #(.TENS_LAST(tens_cap(g))) u_stage (
            .clk       (clk),
            .rst_n     (rst_n),
            .enable    (stage_en[g]),
            .units     (st_units[g]),
            .tens      (st_tens[g]),
            .carry_out (stage_en[g+1])
        );
    end

    // Register the top-stage carry as the one-cycle wrap pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wrap_q <= 1'b0;
        end else begin
            wrap_q <= stage_en[NUM_STAGES];
        end
    end

    assign hund_units = st_units[STG_HUND];
    assign hund_tens  = st_tens[STG_HUND];
    assign sec_units  = st_units[STG_SEC];
    assign sec_tens   = st_tens[STG_SEC];
    assign min_units  = st_units[STG_MIN];
    assign min_tens   = st_tens[STG_MIN];
    assign wrap       = wrap_q;
endmodule

// File: rtl/stopwatch_core_chk.sv
// Module: property checker for stopwatch_core, attached with bind below.
// Assumes it sees only the top-level ports of the core.
module stopwatch_core_chk #(
    parameter int unsigned HUND_TENS_MAX = 9,
    parameter int unsigned SEC_TENS_MAX  = 5,
    parameter int unsigned MIN_TENS_MAX  = 5
) (
    input logic clk,
    input logic rst_n,
    input logic run,
    input logic tick,
    input logic [3:0] hund_units,
    input logic [3:0] hund_tens,
    input logic [3:0] sec_units,
    input logic [3:0] sec_tens,
    input logic [3:0] min_units,
    input logic [3:0] min_tens,
    input logic wrap
);
    logic [7:0]  hund_val, sec_val, min_val;
    logic        accepted, hund_end, sec_end, min_end;
    logic [23:0] all_digits;

    assign hund_val   = 8'(hund_tens) * 8'd10 + 8'(hund_units);
    assign sec_val    = 8'(sec_tens)  * 8'd10 + 8'(sec_units);
    assign min_val    = 8'(min_tens)  * 8'd10 + 8'(min_units);
    assign accepted   = run && tick;
    assign hund_end   = hund_val == 8'((HUND_TENS_MAX + 1) * 10 - 1);
    assign sec_end    = sec_val  == 8'((SEC_TENS_MAX + 1) * 10 - 1);
    assign min_end    = min_val  == 8'((MIN_TENS_MAX + 1) * 10 - 1);
    assign all_digits = {min_tens, min_units, sec_tens, sec_units, hund_tens, hund_units};

    AST_UNITS_BCD: assert property (@(posedge clk) disable iff (!rst_n)
        hund_units <= 4'd9 && sec_units <= 4'd9 && min_units <= 4'd9); // R7
    AST_TENS_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        hund_tens <= 4'(HUND_TENS_MAX) && sec_tens <= 4'(SEC_TENS_MAX)
        && min_tens <= 4'(MIN_TENS_MAX)); // R7
    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(all_digits) && !wrap); // R3
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        run && !tick |=> $stable(all_digits) && !wrap); // R8
    AST_HUND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        accepted && !hund_end |=> hund_val == $past(hund_val) + 8'd1); // R2
    AST_SEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(accepted && hund_end) |=> $stable(sec_val)); // R4
    AST_SEC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        accepted && hund_end && !sec_end |=> sec_val == $past(sec_val) + 8'd1 && hund_val == 8'd0); // R4
    AST_MIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(accepted && hund_end && sec_end) |=> $stable(min_val)); // R5
    AST_MIN_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        accepted && hund_end && sec_end && !min_end |=> min_val == $past(min_val) + 8'd1 && sec_val == 8'd0); // R5
    AST_WRAP_SET: assert property (@(posedge clk) disable iff (!rst_n)
        accepted && hund_end && sec_end && min_end |=> wrap && all_digits == '0); // R6
    AST_WRAP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !(accepted && hund_end && sec_end && min_end) |=> !wrap); // R6
endmodule

bind stopwatch_core stopwatch_core_chk #(
    .HUND_TENS_MAX (HUND_TENS_MAX),
    .SEC_TENS_MAX  (SEC_TENS_MAX),
    .MIN_TENS_MAX  (MIN_TENS_MAX)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .tick       (tick),
    .hund_units (hund_units),
    .hund_tens  (hund_tens),
    .sec_units  (sec_units),
    .sec_tens   (sec_tens),
    .min_units  (min_units),
    .min_tens   (min_tens),
    .wrap       (wrap)
);

// File: tb/test_stopwatch_core.sv
// Bench: drives a full-size core and a reduced core (all tens limits 1,
// period 8000 ticks) with the same irregular run/tick pattern, and compares
// both against an arithmetic model of the accepted tick count.
module test_stopwatch_core;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 1'b0;
    logic tick = 1'b0;
    int   checks = 0;
    int   fails = 0;

    logic [3:0] f_hu, f_ht, f_su, f_st, f_mu, f_mt, s_hu, s_ht, s_su, s_st, s_mu, s_mt;
    logic       f_wrap, s_wrap;

    always #2.5 clk = ~clk;

    stopwatch_core i_stopwatch_core (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
        .hund_units(f_hu), .hund_tens(f_ht), .sec_units(f_su), .sec_tens(f_st),
        .min_units(f_mu), .min_tens(f_mt), .wrap(f_wrap)
    );

    stopwatch_core #(.HUND_TENS_MAX(1), .SEC_TENS_MAX(1), .MIN_TENS_MAX(1)) i_stopwatch_core_small (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
        .hund_units(s_hu), .hund_tens(s_ht), .sec_units(s_su), .sec_tens(s_st),
        .min_units(s_mu), .min_tens(s_mt), .wrap(s_wrap)
    );

    // Expected {min,sec,hund} as two-digit decimals for n accepted ticks.
    function automatic logic [23:0] model(input int n, input int ht, input int st, input int mt);
        int hm = (ht + 1) * 10;
        int sm = (st + 1) * 10;
        int mm = (mt + 1) * 10;
        int h = n % hm;
        int s = (n / hm) % sm;
        int m = (n / (hm * sm)) % mm;
        return {4'(m / 10), 4'(m % 10), 4'(s / 10), 4'(s % 10), 4'(h / 10), 4'(h % 10)};
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_all(input string rh, input string rs, input string rm, input int n, input logic exp_wrap_s);
        logic [23:0] ef = model(n, 9, 5, 5);
        logic [23:0] es = model(n, 1, 1, 1);
        check(rh, "full hundredths", int'({f_ht, f_hu}), int'(ef[7:0]));
        check(rs, "full seconds",    int'({f_st, f_su}), int'(ef[15:8]));
        check(rm, "full minutes",    int'({f_mt, f_mu}), int'(ef[23:16]));
        check("R6", "full wrap",     int'(f_wrap), 0);
        check(rh, "small hundredths", int'({s_ht, s_hu}), int'(es[7:0]));
        check(rs, "small seconds",    int'({s_st, s_su}), int'(es[15:8]));
        check(rm, "small minutes",    int'({s_mt, s_mu}), int'(es[23:16]));
        check("R6", "small wrap",     int'(s_wrap), int'(exp_wrap_s));
    endtask

    initial begin
        #(5ns * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int n = 0;
        int wraps = 0;
        repeat (3) @(negedge clk);
        check_all("R1", "R1", "R1", 0, 1'b0);
        rst_n = 1'b1;

        // R3: ticks while stopped are ignored.
        run = 1'b0;
        for (int i = 0; i < 30; i++) begin
            tick = 1'b1;
            @(negedge clk);
            check_all("R3", "R3", "R3", 0, 1'b0);
        end

        // Irregular sweep covering R2, R4, R5, R6 and the hold cases R3, R8.
        for (int i = 0; i < 17000; i++) begin
            logic acc;
            string lbl;
            run  = (i % 500) < 450;
            tick = (i % 7) != 3;
            acc  = run && tick;
            lbl  = acc ? "R2" : (run ? "R8" : "R3");
            @(negedge clk);
            if (acc) n++;
            if (acc && n % 8000 == 0) wraps++;
            check_all(lbl, acc ? "R4" : lbl, acc ? "R5" : lbl, n, acc && (n % 8000 == 0));
        end
        check("R6", "small wrap count", wraps, 1);
        check("R5", "full minutes reached", int'({f_mt, f_mu}) >= 1 ? 1 : 0, 1);

        // R1: reset in mid-count while running with ticks.
        run = 1'b1;
        tick = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        check_all("R1", "R1", "R1", 0, 1'b0);
        rst_n = 1'b1;
        n = 0;
        for (int i = 0; i < 250; i++) begin
            @(negedge clk);
            n++;
            check_all("R2", "R4", "R5", n, 1'b0);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule